// File: doc/BRIEF.md
# Iterative Single-Precision Divide and Square-Root Unit

This block computes either a single-precision quotient `a / b` or a square root `sqrt(a)` with a bit-serial recurrence. It sits next to a pipelined arithmetic path as a separate execution resource. It holds no shared state with that path, so it never stalls it. One operation runs at a time. The result and its exception flags appear together with a one-cycle done pulse after a fixed, operation-dependent number of cycles. Operand values do not change that number.

The caller pulses `start_i` for one cycle with the operands, the operation and the rounding mode. A start that arrives while the unit is busy is dropped, and `collide_o` reports it. Subnormal values are treated as zero on the way in and on the way out. Special operands bypass the recurrence, but their results are still held back until the fixed completion cycle.

Top module: `fpds_unit`

## Requirements
- R1: A divide (`op_i`=0) accepted at clock edge k raises `done_o` for one cycle, with `result_o` and `flags_o` valid, after edge k+15.
- R2: A square root (`op_i`=1) accepted at clock edge k raises `done_o` for one cycle, with `result_o` and `flags_o` valid, after edge k+23.
- R3: After reset, `busy_o`, `done_o`, `collide_o`, `result_o` and `flags_o` are all zero. `busy_o` is high from the cycle after an accepted start up to the cycle before `done_o`, and it is low in the `done_o` cycle.
- R4: A `start_i` sampled while `busy_o` is high is ignored: the running operation's result and latency are unchanged, and no extra `done_o` follows. It raises `collide_o` for exactly the next cycle.
- R5: For finite normal operands, the quotient is rounded according to `rm_i`: 0 is nearest-even, 1 is toward zero, 2 is toward +inf, 3 is toward -inf. `flags_o` is {invalid[4], div_by_zero[3], overflow[2], underflow[1], inexact[0]}.
- R6: For a positive normal operand, the square root is rounded per `rm_i` with the same encoding as R5. A square-root result is never negative, except for -0.
- R7: An input with a zero exponent field counts as a zero of its sign. A result whose rounded biased exponent is 0 or less becomes a zero of the result's sign, with underflow and inexact set.
- R8: A divide of a finite nonzero value by zero returns infinity with sign a^b and sets div_by_zero. Both 0/0 and inf/inf return 0x7FC00000 and set invalid. inf/x gives a signed infinity and x/inf gives a signed zero, with no flags.
- R9: The square root of a negative nonzero value, including -inf, returns 0x7FC00000 and sets invalid. sqrt(-0) returns 0x80000000, sqrt(+inf) returns +inf, and no flags are set in either case.
- R10: When the rounded exponent reaches 255, overflow and inexact are set. The result is infinity for nearest-even, and also for directed rounding toward the result's own sign. Otherwise it is the largest finite value of that sign.
- R11: Any NaN operand gives 0x7FC00000. Invalid is set only when a NaN operand is signaling (fraction bit 22 clear).
- R12: Inexact is set exactly when the exact quotient or root is not representable in 24 significant bits, that is, when a guard bit, sticky bit or final remainder is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| op_i | input | 1 | 0 divide, 1 square root |
| a_i | input | 32 | Dividend or radicand |
| b_i | input | 32 | Divisor (ignored for square root) |
| rm_i | input | 2 | Rounding mode |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Result valid pulse |
| result_o | output | 32 | Packed single-precision result |
| flags_o | output | 5 | Exception flags |
| collide_o | output | 1 | Start dropped while busy |

## Verification
The bench builds the unit with its defaults: latencies of 15 and 23 cycles and two recurrence steps per cycle. The recurrence therefore finishes after 13 cycles, while the done pulse is still some cycles away. Colliding starts are injected both while the recurrence is running and after it has finished, before done. The random operands include exponents near both range limits, so that overflow, flush-to-zero underflow and rounding carry-out into the exponent all occur.

// File: rtl/fpds_pkg.sv
package fpds_pkg;
  localparam int QW = 26;  // 24 significant + guard + one extra bit
  typedef enum logic {OP_DIV = 1'b0, OP_SQRT = 1'b1} op_e;
  typedef enum logic [1:0] {RM_RNE = 2'd0, RM_RTZ = 2'd1, RM_RUP = 2'd2, RM_RDN = 2'd3} rm_e;
  typedef struct packed {
    logic nv;
    logic dz;
    logic of;
    logic uf;
    logic nx;
  } flags_t;
  localparam logic [31:0] QNAN = 32'h7FC0_0000;
endpackage

// File: rtl/fpds_prep.sv
module fpds_prep
  import fpds_pkg::*;
(
  input  logic               op_i,
  input  logic [31:0]        a_i,
  input  logic [31:0]        b_i,
  output logic               special_o,
  output logic [31:0]        spec_res_o,
  output flags_t             spec_flags_o,
  output logic               sign_o,
  output logic signed [9:0]  exp_o,
  output logic [28:0]        rem_o,
  output logic [51:0]        x_o,
  output logic [23:0]        dvsr_o
);
  logic [7:0] ea, eb;
  logic [23:0] ma, mb;
  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, a_snan, b_snan;
  logic nan_in, snan_in, lt;
  logic [9:0] sq_t;

  assign ea = a_i[30:23];
  assign eb = b_i[30:23];
  assign ma = {1'b1, a_i[22:0]};
  assign mb = {1'b1, b_i[22:0]};
  assign a_zero = (ea == 8'h00);
  assign b_zero = (eb == 8'h00);
  assign a_inf  = (ea == 8'hFF) && (a_i[22:0] == '0);
  assign b_inf  = (eb == 8'hFF) && (b_i[22:0] == '0);
  assign a_nan  = (ea == 8'hFF) && (a_i[22:0] != '0);
  assign b_nan  = (eb == 8'hFF) && (b_i[22:0] != '0);
  assign a_snan = a_nan && !a_i[22];
  assign b_snan = b_nan && !b_i[22];
  assign nan_in  = (op_i == OP_SQRT) ? a_nan  : (a_nan | b_nan);
  assign snan_in = (op_i == OP_SQRT) ? a_snan : (a_snan | b_snan);
  assign lt = (ma < mb);
  assign sq_t = {2'b00, ea} + (ea[0] ? 10'd127 : 10'd126);

  assign sign_o = (op_i == OP_SQRT) ? 1'b0 : (a_i[31] ^ b_i[31]);
  assign dvsr_o = mb;

  always_comb begin
    if (op_i == OP_SQRT) begin
      exp_o = $signed({1'b0, sq_t[9:1]});
      rem_o = '0;
      // odd unbiased exponent (even biased) pre-doubles the radicand
      x_o   = ea[0] ? {1'b0, ma, 27'b0} : {ma, 28'b0};
    end else begin
      exp_o = $signed({2'b00, ea}) - $signed({2'b00, eb}) + 10'sd127 - $signed({9'b0, lt});
      rem_o = lt ? {4'b0, ma, 1'b0} : {5'b0, ma};
      x_o   = '0;
    end
  end

  always_comb begin
    special_o    = 1'b0;
    spec_res_o   = '0;
    spec_flags_o = '0;
    if (nan_in) begin
      special_o       = 1'b1;
      spec_res_o      = QNAN;
      spec_flags_o.nv = snan_in;
    end else if (op_i == OP_DIV) begin
      if ((a_zero && b_zero) || (a_inf && b_inf)) begin
        special_o       = 1'b1;
        spec_res_o      = QNAN;
        spec_flags_o.nv = 1'b1;
      end else if (a_inf || b_zero) begin
        special_o       = 1'b1;
        spec_res_o      = {sign_o, 8'hFF, 23'b0};
        spec_flags_o.dz = b_zero && !a_inf;
      end else if (a_zero || b_inf) begin
        special_o  = 1'b1;
        spec_res_o = {sign_o, 31'b0};
      end
    end else begin
      if (a_zero) begin
        special_o  = 1'b1;
        spec_res_o = {a_i[31], 31'b0};
      end else if (a_i[31]) begin
        special_o       = 1'b1;
        spec_res_o      = QNAN;
        spec_flags_o.nv = 1'b1;
      end else if (a_inf) begin
        special_o  = 1'b1;
        spec_res_o = 32'h7F80_0000;
      end
    end
  end
endmodule

// File: rtl/fpds_recur.sv
module fpds_recur
  import fpds_pkg::*;
#(
  parameter int STEPS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          op_i,
  input  logic [28:0]   rem_i,
  input  logic [51:0]   x_i,
  input  logic [23:0]   dvsr_i,
  output logic [QW-1:0] q_o,
  output logic          rem_nz_o
);
  localparam int ITERS = (QW + STEPS - 1) / STEPS;
  localparam int IW    = $clog2(ITERS + 1);

  logic [28:0]   rem_q, rem_n;
  logic [QW-1:0] q_q, q_n;
  logic [51:0]   x_q, x_n;
  logic [23:0]   dv_q;
  logic          op_q;
  logic [IW-1:0] left_q;

  // STEPS restoring radix-2 steps per cycle
  always_comb begin
    logic [28:0] rp, trial, rn;
    logic qb;
    rem_n = rem_q;
    q_n   = q_q;
    x_n   = x_q;
    for (int i = 0; i < STEPS; i++) begin
      if (op_q == OP_SQRT) begin
        rp    = {rem_n[26:0], x_n[51:50]};
        trial = {1'b0, q_n, 2'b01};
      end else begin
        rp    = rem_n;
        trial = {5'b0, dv_q};
      end
      qb    = (rp >= trial);
      rn    = qb ? (rp - trial) : rp;
      rem_n = (op_q == OP_SQRT) ? rn : {rn[27:0], 1'b0};
      q_n   = {q_n[QW-2:0], qb};
      x_n   = {x_n[49:0], 2'b00};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      q_q    <= '0;
      x_q    <= '0;
      dv_q   <= '0;
      op_q   <= 1'b0;
      left_q <= '0;
    end else if (load_i) begin
      rem_q  <= rem_i;
      q_q    <= '0;
      x_q    <= x_i;
      dv_q   <= dvsr_i;
      op_q   <= op_i;
      left_q <= IW'(ITERS);
    end else if (left_q != '0) begin
      rem_q  <= rem_n;
      q_q    <= q_n;
      x_q    <= x_n;
      left_q <= left_q - 1'b1;
    end
  end

  assign q_o      = q_q;
  assign rem_nz_o = (rem_q != '0);
endmodule

// File: rtl/fpds_round.sv
module fpds_round
  import fpds_pkg::*;
(
  input  logic              sign_i,
  input  logic signed [9:0] exp_i,
  input  logic [QW-1:0]     q_i,
  input  logic              rem_nz_i,
  input  logic [1:0]        rm_i,
  input  logic              special_i,
  input  logic [31:0]       spec_res_i,
  input  flags_t            spec_flags_i,
  output logic [31:0]       res_o,
  output flags_t            flags_o
);
  logic guard, sticky, inexact, up, to_inf;
  logic [24:0] sum;
  logic signed [9:0] e;

  assign guard   = q_i[1];
  assign sticky  = q_i[0] | rem_nz_i;
  assign inexact = guard | sticky;

  always_comb begin
    case (rm_e'(rm_i))
      RM_RNE:  up = guard & (sticky | q_i[2]);
      RM_RTZ:  up = 1'b0;
      RM_RUP:  up = !sign_i & inexact;
      default: up = sign_i & inexact;
    endcase
  end

  assign sum    = {1'b0, q_i[QW-1:2]} + {24'b0, up};
  assign e      = exp_i + $signed({9'b0, sum[24]});
  assign to_inf = (rm_i == RM_RNE) || (rm_i == RM_RUP && !sign_i) || (rm_i == RM_RDN && sign_i);

  always_comb begin
    flags_o = '0;
    if (special_i) begin
      res_o   = spec_res_i;
      flags_o = spec_flags_i;
    end else if (e >= 10'sd255) begin
      res_o      = to_inf ? {sign_i, 8'hFF, 23'b0} : {sign_i, 8'hFE, 23'h7FFFFF};
      flags_o.of = 1'b1;
      flags_o.nx = 1'b1;
    end else if (e <= 10'sd0) begin
      res_o      = {sign_i, 31'b0};
      flags_o.uf = 1'b1;
      flags_o.nx = 1'b1;
    end else begin
      res_o      = {sign_i, e[7:0], sum[22:0]};
      flags_o.nx = inexact;
    end
  end
endmodule

// File: rtl/fpds_unit.sv
module fpds_unit
  import fpds_pkg::*;
#(
  parameter int DIV_LAT  = 15,
  parameter int SQRT_LAT = 23,
  parameter int STEPS    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        op_i,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [1:0]  rm_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] result_o,
  output logic [4:0]  flags_o,
  output logic        collide_o
);
  localparam int MAX_LAT = (DIV_LAT > SQRT_LAT) ? DIV_LAT : SQRT_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1);

  logic accept;
  logic p_special, p_sign;
  logic [31:0] p_spec_res;
  flags_t p_spec_flags;
  logic signed [9:0] p_exp;
  logic [28:0] p_rem;
  logic [51:0] p_x;
  logic [23:0] p_dvsr;

  logic [CW-1:0] cnt_q;
  logic busy_q, done_q, coll_q;
  logic [31:0] res_q;
  flags_t flags_q;
  logic spec_q, sign_q;
  logic [31:0] spec_res_q;
  flags_t spec_flags_q;
  logic signed [9:0] exp_q;
  logic [1:0] rm_q;

  logic [QW-1:0] core_q;
  logic core_rem_nz;
  logic [31:0] rnd_res;
  flags_t rnd_flags;

  assign accept = start_i && !busy_q;

  fpds_prep u_prep (
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .special_o   (p_special),
    .spec_res_o  (p_spec_res),
    .spec_flags_o(p_spec_flags),
    .sign_o      (p_sign),
    .exp_o       (p_exp),
    .rem_o       (p_rem),
    .x_o         (p_x),
    .dvsr_o      (p_dvsr)
  );

  fpds_recur #(.STEPS(STEPS)) u_recur (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .op_i    (op_i),
    .rem_i   (p_rem),
    .x_i     (p_x),
    .dvsr_i  (p_dvsr),
    .q_o     (core_q),
    .rem_nz_o(core_rem_nz)
  );

  fpds_round u_round (
    .sign_i      (sign_q),
    .exp_i       (exp_q),
    .q_i         (core_q),
    .rem_nz_i    (core_rem_nz),
    .rm_i        (rm_q),
    .special_i   (spec_q),
    .spec_res_i  (spec_res_q),
    .spec_flags_i(spec_flags_q),
    .res_o       (rnd_res),
    .flags_o     (rnd_flags)
  );

  // fixed-latency sequencer; recurrence finishes well before cnt expires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      coll_q       <= 1'b0;
      res_q        <= '0;
      flags_q      <= '0;
      spec_q       <= 1'b0;
      sign_q       <= 1'b0;
      spec_res_q   <= '0;
      spec_flags_q <= '0;
      exp_q        <= '0;
      rm_q         <= '0;
    end else begin
      done_q <= 1'b0;
      coll_q <= start_i && busy_q;
      if (accept) begin
        busy_q       <= 1'b1;
        cnt_q        <= (op_i == OP_SQRT) ? CW'(SQRT_LAT) : CW'(DIV_LAT);
        spec_q       <= p_special;
        sign_q       <= p_sign;
        spec_res_q   <= p_spec_res;
        spec_flags_q <= p_spec_flags;
        exp_q        <= p_exp;
        rm_q         <= rm_i;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          res_q   <= rnd_res;
          flags_q <= rnd_flags;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign collide_o = coll_q;
  assign result_o  = res_q;
  assign flags_o   = flags_q;
endmodule

// File: rtl/fpds_unit_chk.sv
module fpds_unit_chk #(
  parameter int DIV_LAT  = 15,
  parameter int SQRT_LAT = 23
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        op_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        collide_o,
  input logic [31:0] result_o,
  input logic [4:0]  flags_o
);
  logic [15:0] since_q;
  logic [15:0] lat_q;
  logic        op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      lat_q   <= '0;
      op_q    <= 1'b0;
    end else if (start_i && !busy_o) begin
      since_q <= 16'd1;
      lat_q   <= op_i ? 16'(SQRT_LAT) : 16'(DIV_LAT);
      op_q    <= op_i;
    end else if (since_q != 16'hFFFF) begin
      since_q <= since_q + 16'd1;
    end
  end

  AST_LATENCY_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> since_q == lat_q + 16'd1); // R1 R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R3
  AST_COLLIDE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> collide_o); // R4
  AST_COLLIDE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && busy_o) |=> !collide_o); // R4
  AST_SQRT_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q && result_o[30:0] != '0) |-> !result_o[31]); // R6
  AST_DZ_DIV_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flags_o[3]) |-> !op_q); // R8
  AST_INVALID_QNAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flags_o[4]) |-> result_o == 32'h7FC0_0000); // R11
endmodule

bind fpds_unit fpds_unit_chk #(.DIV_LAT(DIV_LAT), .SQRT_LAT(SQRT_LAT)) u_chk (.*);

// File: tb/sim_fpds_unit.sv
`timescale 1ns/1ps
module sim_fpds_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [1:0] rm = '0;
  logic busy, done, collide;
  logic [31:0] result;
  logic [4:0] flags;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fpds_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .rm_i(rm), .busy_o(busy), .done_o(done), .result_o(result), .flags_o(flags),
    .collide_o(collide)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // expected {flags, result}, flags = {nv,dz,of,uf,nx}
  function automatic logic [36:0] ref_calc(input logic o, input logic [31:0] x, input logic [31:0] y,
                                           input logic [1:0] m);
    int ea, eb, e;
    logic sa, s, az, bz, ai, bi, an, bn, g, st, up, inx;
    logic [63:0] num, q, r, rad, root, cand;
    logic [24:0] sig;
    ea = int'(x[30:23]); eb = int'(y[30:23]);
    sa = x[31];
    az = (ea == 0); bz = (eb == 0);
    ai = (ea == 255) && (x[22:0] == 0); bi = (eb == 255) && (y[22:0] == 0);
    an = (ea == 255) && (x[22:0] != 0); bn = (eb == 255) && (y[22:0] != 0);
    if (o == 1'b0) begin
      s = x[31] ^ y[31];
      if (an || bn) return {(an && !x[22]) || (bn && !y[22]), 4'b0, 32'h7FC00000};
      if ((az && bz) || (ai && bi)) return {5'b10000, 32'h7FC00000};
      if (ai) return {5'b0, s, 8'hFF, 23'b0};
      if (bz) return {5'b01000, s, 8'hFF, 23'b0};
      if (az || bi) return {5'b0, s, 31'b0};
      num = 64'({1'b1, x[22:0]});
      if (x[22:0] < y[22:0]) begin num = num << 26; e = ea - eb + 126; end
      else begin num = num << 25; e = ea - eb + 127; end
      q = num / 64'({1'b1, y[22:0]});
      r = num % 64'({1'b1, y[22:0]});
    end else begin
      s = 1'b0;
      if (an) return {!x[22], 4'b0, 32'h7FC00000};
      if (az) return {5'b0, sa, 31'b0};
      if (sa) return {5'b10000, 32'h7FC00000};
      if (ai) return {5'b0, 32'h7F800000};
      rad = 64'({1'b1, x[22:0]}) << ((ea % 2 == 1) ? 27 : 28);
      e = (ea % 2 == 1) ? (ea + 127) / 2 : (ea + 126) / 2;
      root = 0;
      for (int i = 25; i >= 0; i--) begin
        cand = root | (64'd1 << i);
        if (cand * cand <= rad) root = cand;
      end
      q = root;
      r = rad - root * root;
    end
    g = q[1]; st = q[0] | (r != 0); inx = g | st;
    case (m)
      2'd0: up = g & (st | q[2]);
      2'd1: up = 1'b0;
      2'd2: up = !s & inx;
      default: up = s & inx;
    endcase
    sig = {1'b0, q[25:2]} + 25'(up);
    if (sig[24]) e = e + 1;
    if (e >= 255) begin
      if (m == 2'd0 || (m == 2'd2 && !s) || (m == 2'd3 && s)) return {5'b00101, s, 8'hFF, 23'b0};
      return {5'b00101, s, 8'hFE, 23'h7FFFFF};
    end
    if (e <= 0) return {5'b00011, s, 31'b0};
    return {4'b0, inx, s, 8'(e), sig[22:0]};
  endfunction

  // coll_at: cycle index (1..) after start at which a second start is driven; 0 for none
  task automatic run_op(input logic o, input logic [31:0] x, input logic [31:0] y, input logic [1:0] m,
                        input int coll_at, input string req);
    logic [36:0] exp_v;
    int j;
    exp_v = ref_calc(o, x, y, m);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; rm = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R3 busy after start", 64'(busy), 64'd1);
    j = 1;
    while (done !== 1'b1 && j < 200) begin
      if (j == coll_at) begin
        start = 1'b1; op = ~o; a = 32'h4080_0000; b = 32'h3F80_0000; rm = 2'd1;
      end
      @(negedge clk);
      j++;
      if (start) begin
        start = 1'b0;
        chk(collide === 1'b1, "R4 collide pulse", 64'(collide), 64'd1);
      end else if (j > 2) begin
        chk(collide === 1'b0, "R4 collide idle", 64'(collide), 64'd0);
      end
    end
    if (o) chk(j - 1 == 23, "R2 sqrt latency", 64'(j - 1), 64'd23);
    else   chk(j - 1 == 15, "R1 div latency", 64'(j - 1), 64'd15);
    chk(busy === 1'b0, "R3 busy low at done", 64'(busy), 64'd0);
    chk({flags, result} === exp_v, req, 64'({flags, result}), 64'(exp_v));
    if (coll_at != 0) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R4 no extra op", 64'({done, busy}), 64'd0);
      end
    end
  endtask

  function automatic logic [31:0] rand_fp(input bit for_sqrt);
    logic [31:0] v;
    int k;
    v = $urandom;
    k = int'($urandom % 16);
    if (k == 0) v[30:23] = 8'h00;
    else if (k == 1) v[30:23] = 8'hFF;
    else if (k == 2) v[30:0] = '0;
    else if (k > 4) v[30:23] = 8'(96 + ($urandom % 64));
    if (for_sqrt && k > 3) v[31] = 1'b0;
    return v;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R3 reset state
    chk({busy, done, collide, result, flags} === '0, "R3 reset state",
        64'({busy, done, collide, result, flags}), 64'd0);
    rst_n = 1'b1;
    // R5 1/3 in all rounding modes
    for (int m = 0; m < 4; m++) run_op(1'b0, 32'h3F80_0000, 32'h4040_0000, 2'(m), 0, "R5 1/3");
    run_op(1'b0, 32'hBF80_0000, 32'h4040_0000, 2'd3, 0, "R5 -1/3 down");
    run_op(1'b0, 32'h3F80_0000, 32'h4040_0000, 2'd0, 0, "R5 1/3 rne");
    chk(result === 32'h3EAA_AAAB, "R5 1/3 literal", 64'(result), 64'h3EAAAAAB);
    // R12 exact results
    run_op(1'b0, 32'h40C0_0000, 32'h4000_0000, 2'd0, 0, "R12 6/2");
    chk(result === 32'h4040_0000 && flags === 5'b0, "R12 6/2 exact", 64'({flags, result}), 64'h40400000);
    run_op(1'b1, 32'h4080_0000, 32'h0, 2'd0, 0, "R12 sqrt4");
    chk(result === 32'h4000_0000 && flags === 5'b0, "R12 sqrt4 exact", 64'({flags, result}), 64'h40000000);
    // R6 sqrt 2 all modes
    for (int m = 0; m < 4; m++) run_op(1'b1, 32'h4000_0000, 32'h0, 2'(m), 0, "R6 sqrt2");
    // R8 specials
    run_op(1'b0, 32'h3F80_0000, 32'h0000_0000, 2'd0, 0, "R8 1/0");
    chk(result === 32'h7F80_0000 && flags === 5'b01000, "R8 1/0 literal", 64'({flags, result}), 64'h87F800000);
    run_op(1'b0, 32'hBF80_0000, 32'h0000_0000, 2'd0, 0, "R8 -1/0");
    run_op(1'b0, 32'h0000_0000, 32'h8000_0000, 2'd0, 0, "R8 0/0");
    run_op(1'b0, 32'h7F80_0000, 32'hFF80_0000, 2'd0, 0, "R8 inf/inf");
    run_op(1'b0, 32'h7F80_0000, 32'h0000_0000, 2'd0, 0, "R8 inf/0");
    run_op(1'b0, 32'h4000_0000, 32'hFF80_0000, 2'd0, 0, "R8 x/inf");
    // R9
    run_op(1'b1, 32'hC080_0000, 32'h0, 2'd0, 0, "R9 sqrt neg");
    run_op(1'b1, 32'h8000_0000, 32'h0, 2'd0, 0, "R9 sqrt -0");
    chk(result === 32'h8000_0000 && flags === 5'b0, "R9 sqrt -0 literal", 64'({flags, result}), 64'h80000000);
    run_op(1'b1, 32'hFF80_0000, 32'h0, 2'd0, 0, "R9 sqrt -inf");
    run_op(1'b1, 32'h7F80_0000, 32'h0, 2'd0, 0, "R9 sqrt +inf");
    // R7 flush to zero
    run_op(1'b0, 32'h0000_0001, 32'h3F80_0000, 2'd0, 0, "R7 sub/x");
    run_op(1'b0, 32'h3F80_0000, 32'h0040_0000, 2'd0, 0, "R7 x/sub");
    run_op(1'b1, 32'h8000_0005, 32'h0, 2'd0, 0, "R7 sqrt -sub");
    run_op(1'b0, 32'h0080_0000, 32'h4000_0000, 2'd0, 0, "R7 tiny");
    chk(result === 32'h0 && flags === 5'b00011, "R7 tiny literal", 64'({flags, result}), 64'h300000000);
    run_op(1'b0, 32'h8080_0000, 32'h4040_0000, 2'd2, 0, "R7 neg tiny");
    // R10 overflow per mode and sign
    for (int m = 0; m < 4; m++) begin
      run_op(1'b0, 32'h7F7F_FFFF, 32'h3F00_0000, 2'(m), 0, "R10 ovf +");
      run_op(1'b0, 32'h7F7F_FFFF, 32'hBF00_0000, 2'(m), 0, "R10 ovf -");
    end
    // R11 NaN
    run_op(1'b0, 32'h7FC0_0001, 32'h3F80_0000, 2'd0, 0, "R11 qnan");
    run_op(1'b0, 32'h3F80_0000, 32'h7F80_0001, 2'd0, 0, "R11 snan");
    run_op(1'b1, 32'hFF80_0003, 32'h0, 2'd0, 0, "R11 sqrt snan");
    // R4 collisions, during and after recurrence
    run_op(1'b0, 32'h3F80_0000, 32'h4040_0000, 2'd0, 3, "R4 div coll early");
    run_op(1'b0, 32'h4049_0FDB, 32'h402D_F854, 2'd2, 14, "R4 div coll late");
    run_op(1'b1, 32'h4000_0000, 32'h0, 2'd1, 20, "R4 sqrt coll");
    // random
    for (int i = 0; i < 400; i++) begin
      logic o;
      o = 1'($urandom % 2);
      run_op(o, rand_fp(o), rand_fp(1'b0), 2'($urandom % 4), (i % 9 == 0) ? 2 + i % 12 : 0,
             o ? "R6 R12 random sqrt" : "R5 R12 random div");
    end
    summary();
  end
endmodule